// File: doc/BRIEF.md
# Microcoded Control Sequencer for a 4-bit Datapath

This block is the control unit of a small 4-bit processor. It runs from a table rather than from hand-built state logic. An instruction register keeps the opcode of the instruction being executed. A two-bit step counter tracks which micro-operation of that instruction is current. The two are joined, opcode in the upper four bits and step in the lower two, to form a six-bit index into a 64-entry control table. The entry selected in this way is the 16-bit control word that drives the datapath. This word covers bus sources, ALU mode, register and memory loads, and the program-counter controls.

Every instruction starts with the same fetch micro-operation. The fetch reads the next program byte with the program counter as the address, advances the program counter and captures the opcode input into the instruction register. After the fetch, the step counter walks through the opcode's own micro-operations. A dedicated bit in each word marks the final micro-operation, and at that point the counter goes back to the fetch step. The table contents are computed from constants inside the design. Table slots that no instruction uses hold a safe word that loads nothing and ends the instruction at once.

Step states, in counting order: `STEP_FETCH` (0), `STEP_1`, `STEP_2`, `STEP_3`. There are two transitions. **advance** moves to the next state when the current word's last-step bit is clear. **restart** returns to `STEP_FETCH` when that bit is set, or on reset.

Top module: `ucode_sequencer`

## Requirements
- R1: A synchronous active-high `rst` clears the instruction register to 0 and the step counter to `STEP_FETCH`, so the first word after reset is the fetch word 0x1205.
- R2: `ctrl_word` is the table entry at index {IR[3:0], step[1:0]} and follows the registers within the same cycle, with no extra register stage.
- R3: Step 0 of every opcode holds the fetch word 0x1205. This word sets bit 0 (address from program counter), bit 2 (program counter increment), bit 9 (memory read) and bit 12 (IR load).
- R4: The IR takes the `opcode` input only at a clock edge where the current word has bit 12 set; at every other edge it keeps its value, and `opcode` changes have no effect on the words.
- R5: Bit 15 of a word marks the last micro-step. When it is set, the step counter returns to 0; when it is clear, the counter increments by one.
- R6: Opcode programs (step 1, step 2): 0 NOP {0x8000}; 1 load {0x0605, 0xA220}; 2 add {0x0605, 0xA210}; 3 and {0x0605, 0xA200}; 4 store {0x0605, 0x8900}; 5 invert {0xA040}; 6 negate {0xA0C0}; 7 input {0xA022}; 8 output {0xC100}; 9 jump {0x8209}.
- R7: Every other non-fetch entry holds the safe word 0x8000. This covers opcodes 10 to 15, all of step 3, and the steps after an instruction's last step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 4 | Opcode presented by program memory, captured during fetch |
| ctrl_word | output | 16 | Control word for the current micro-step |

## Verification
The IR and the step counter can only be seen at the port through `ctrl_word`. A wrong step value therefore shows as a wrong word in the very cycle it exists: a missed restart produces a safe word or a later micro-op in place of 0x1205. A wrong IR value appears one cycle after the fetch, as step 1 of the wrong program. Since every cycle's word is compared with a reference model, a fault shows up within one cycle of the step or IR value going wrong. Opcodes that change during non-fetch steps, and resets arriving in the middle of an instruction, exercise the hold and restart paths.

// File: rtl/ucode_pkg.sv
package ucode_pkg;

    localparam int OP_W    = 4;
    localparam int STEP_W  = 2;
    localparam int CW_W    = 16;
    localparam int ADDR_W  = OP_W + STEP_W;
    localparam int DEPTH   = 1 << ADDR_W;

    typedef enum logic [STEP_W-1:0] {
        STEP_FETCH = 2'd0,
        STEP_1     = 2'd1,
        STEP_2     = 2'd2,
        STEP_3     = 2'd3
    } step_e;

    // control bit positions
    localparam int CB_PC_ADDR  = 0;
    localparam int CB_IN_BUS   = 1;
    localparam int CB_PC_INC   = 2;
    localparam int CB_PC_LOAD  = 3;
    localparam int CB_ALU_ADD  = 4;
    localparam int CB_ALU_PASS = 5;
    localparam int CB_INVERT   = 6;
    localparam int CB_NEGATE   = 7;
    localparam int CB_ACC_BUS  = 8;
    localparam int CB_MEM_RD   = 9;
    localparam int CB_MAR_LD   = 10;
    localparam int CB_MEM_WR   = 11;
    localparam int CB_IR_LD    = 12;
    localparam int CB_ACC_LD   = 13;
    localparam int CB_OUT_LD   = 14;
    localparam int CB_LAST     = 15;

    typedef logic [CW_W-1:0] cword_t;

    localparam cword_t BIT1 = cword_t'(1);

    localparam cword_t W_FETCH   = (BIT1 << CB_PC_ADDR) | (BIT1 << CB_PC_INC)
                                 | (BIT1 << CB_MEM_RD)  | (BIT1 << CB_IR_LD);
    localparam cword_t W_SAFE    = (BIT1 << CB_LAST);
    localparam cword_t W_OPERAND = (BIT1 << CB_PC_ADDR) | (BIT1 << CB_MEM_RD)
                                 | (BIT1 << CB_MAR_LD)  | (BIT1 << CB_PC_INC);

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 4'd0,
        OP_LOAD = 4'd1,
        OP_ADD  = 4'd2,
        OP_AND  = 4'd3,
        OP_STO  = 4'd4,
        OP_INV  = 4'd5,
        OP_NEG  = 4'd6,
        OP_IN   = 4'd7,
        OP_OUT  = 4'd8,
        OP_JMP  = 4'd9
    } opcode_e;

    localparam int LAST_OP = 9;

    function automatic cword_t exec_word(input logic [OP_W-1:0] op,
                                         input logic [STEP_W-1:0] st);
        cword_t w;
        w = W_SAFE;
        if (st == STEP_1) begin
            case (op)
                OP_NOP:  w = W_SAFE;
                OP_LOAD, OP_ADD, OP_AND, OP_STO: w = W_OPERAND;
                OP_INV:  w = (BIT1 << CB_INVERT) | (BIT1 << CB_ACC_LD) | (BIT1 << CB_LAST);
                OP_NEG:  w = (BIT1 << CB_INVERT) | (BIT1 << CB_NEGATE)
                           | (BIT1 << CB_ACC_LD) | (BIT1 << CB_LAST);
                OP_IN:   w = (BIT1 << CB_IN_BUS) | (BIT1 << CB_ALU_PASS)
                           | (BIT1 << CB_ACC_LD) | (BIT1 << CB_LAST);
                OP_OUT:  w = (BIT1 << CB_ACC_BUS) | (BIT1 << CB_OUT_LD) | (BIT1 << CB_LAST);
                OP_JMP:  w = (BIT1 << CB_PC_ADDR) | (BIT1 << CB_MEM_RD)
                           | (BIT1 << CB_PC_LOAD) | (BIT1 << CB_LAST);
                default: w = W_SAFE;
            endcase
        end else if (st == STEP_2) begin
            case (op)
                OP_LOAD: w = (BIT1 << CB_MEM_RD) | (BIT1 << CB_ALU_PASS)
                           | (BIT1 << CB_ACC_LD) | (BIT1 << CB_LAST);
                OP_ADD:  w = (BIT1 << CB_MEM_RD) | (BIT1 << CB_ALU_ADD)
                           | (BIT1 << CB_ACC_LD) | (BIT1 << CB_LAST);
                OP_AND:  w = (BIT1 << CB_MEM_RD) | (BIT1 << CB_ACC_LD) | (BIT1 << CB_LAST);
                OP_STO:  w = (BIT1 << CB_ACC_BUS) | (BIT1 << CB_MEM_WR) | (BIT1 << CB_LAST);
                default: w = W_SAFE;
            endcase
        end
        return w;
    endfunction

    function automatic cword_t ucode_word(input logic [OP_W-1:0] op,
                                          input logic [STEP_W-1:0] st);
        if (st == STEP_FETCH) return W_FETCH;
        return exec_word(op, st);
    endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
    import ucode_pkg::*;
#(
    parameter int A_W = ADDR_W,
    parameter int D_W = CW_W
) (
    input  logic [A_W-1:0] addr,
    output logic [D_W-1:0] word
);
    localparam int ENTRIES = 1 << A_W;

    logic [D_W-1:0] table_q [ENTRIES];

    for (genvar a = 0; a < ENTRIES; a++) begin : g_entry
        localparam logic [A_W-1:0] IDX = A_W'(a);
        assign table_q[a] = D_W'(ucode_word(IDX[A_W-1:STEP_W], IDX[STEP_W-1:0]));
    end

    assign word = table_q[addr];

endmodule

// File: rtl/ucode_ir.sv
module ucode_ir
    import ucode_pkg::*;
#(
    parameter int W = OP_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    assert_ir_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

    assert_ir_capture_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

endmodule

// File: rtl/ucode_stepper.sv
module ucode_stepper
    import ucode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  last,
    output step_e step
);
    step_e step_d;

    always_ff @(posedge clk) begin
        if (rst) step <= STEP_FETCH;
        else     step <= step_d;
    end

    always_comb begin
        step_d = STEP_FETCH;
        if (!last) begin
            unique case (step)
                STEP_FETCH: step_d = STEP_1;
                STEP_1:     step_d = STEP_2;
                STEP_2:     step_d = STEP_3;
                STEP_3:     step_d = STEP_FETCH;
            endcase
        end
    end

    assert_reset_fetch_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (step == STEP_FETCH));

    assert_restart_R5: assert property (@(posedge clk) disable iff (rst)
        last |=> (step == STEP_FETCH));

    assert_advance_R5: assert property (@(posedge clk) disable iff (rst)
        !last |=> (step == step_e'($past(step) + 2'd1)));

endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import ucode_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    output logic [CW_W-1:0] ctrl_word
);
    logic [OP_W-1:0]   ir_q;
    step_e             step_q;
    logic [ADDR_W-1:0] rom_addr;

    assign rom_addr = {ir_q, step_q};

    ucode_ir #(.W(OP_W)) u_ir (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl_word[CB_IR_LD]),
        .d    (opcode),
        .q    (ir_q)
    );

    ucode_stepper u_step (
        .clk  (clk),
        .rst  (rst),
        .last (ctrl_word[CB_LAST]),
        .step (step_q)
    );

    ucode_rom #(.A_W(ADDR_W), .D_W(CW_W)) u_rom (
        .addr (rom_addr),
        .word (ctrl_word)
    );

    assert_fetch_word_R3: assert property (@(posedge clk) disable iff (rst)
        (step_q == STEP_FETCH) |-> (ctrl_word == 16'h1205));

    assert_unused_safe_R7: assert property (@(posedge clk) disable iff (rst)
        ((int'(ir_q) > LAST_OP) && (step_q != STEP_FETCH)) |-> (ctrl_word == 16'h8000));

    assert_step3_safe_R7: assert property (@(posedge clk) disable iff (rst)
        (step_q == STEP_3) |-> (ctrl_word == 16'h8000));

    assert_fetch_follows_R2: assert property (@(posedge clk) disable iff (rst)
        ctrl_word[CB_LAST] |=> (ctrl_word == 16'h1205));

endmodule

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  opcode = 4'd0;
    logic [15:0] ctrl_word;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    ucode_sequencer dut (
        .clk       (clk),
        .rst       (rst),
        .opcode    (opcode),
        .ctrl_word (ctrl_word)
    );

    always #5 clk = ~clk;

    // Reference: each opcode's program as a queue of words after the fetch (R6)
    function automatic void program_of(input int op, ref logic [15:0] prog[$]);
        prog = {};
        case (op)
            0: prog = '{16'h8000};
            1: prog = '{16'h0605, 16'hA220};
            2: prog = '{16'h0605, 16'hA210};
            3: prog = '{16'h0605, 16'hA200};
            4: prog = '{16'h0605, 16'h8900};
            5: prog = '{16'hA040};
            6: prog = '{16'hA0C0};
            7: prog = '{16'hA022};
            8: prog = '{16'hC100};
            9: prog = '{16'h8209};
            default: prog = '{16'h8000};
        endcase
    endfunction

    function automatic logic [15:0] model_word(input int op, input int st);
        logic [15:0] prog[$];
        if (st == 0) return 16'h1205;              // R3
        program_of(op, prog);
        if (st - 1 < prog.size()) return prog[st-1];  // R6
        return 16'h8000;                            // R7
    endfunction

    int  m_ir = 0;
    int  m_step = 0;
    bit  m_after_reset = 1;

    task automatic compare();
        logic [15:0] exp;
        string tag;
        exp = model_word(m_ir, m_step);
        if (m_after_reset)      tag = "R1";
        else if (m_step == 0)   tag = "R3";
        else if (m_ir > 9)      tag = "R7";
        else                    tag = "R6";
        checks++;
        if (ctrl_word !== exp) begin
            fails++;
            $display("FAIL %s (R2/R4/R5 state) ir=%0d step=%0d actual=%h expected=%h",
                     tag, m_ir, m_step, ctrl_word, exp);
        end
    endtask

    // advance the model for the coming edge using current inputs
    task automatic model_edge();
        logic [15:0] w;
        w = model_word(m_ir, m_step);
        if (rst) begin
            m_ir = 0; m_step = 0; m_after_reset = 1;
        end else begin
            m_after_reset = 0;
            if (w[12]) m_ir = int'(opcode);          // R4
            if (w[15]) m_step = 0;                   // R5
            else       m_step = (m_step + 1) % 4;
        end
    endtask

    task automatic cycle(input logic r, input logic [3:0] op);
        @(negedge clk);
        compare();
        rst = r;
        opcode = op;
        model_edge();
    endtask

    initial begin
        rst = 1'b1;
        opcode = 4'd7;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_ir = 0; m_step = 0; m_after_reset = 1;
        model_edge();

        // directed: every opcode held steady, several instructions each
        for (int op = 0; op < 16; op++) begin
            for (int k = 0; k < 8; k++) cycle(1'b0, 4'(op));
        end

        // R4: opcode toggles every cycle, including non-fetch steps
        for (int k = 0; k < 64; k++) cycle(1'b0, 4'(k * 5));

        // R1: reset in the middle of a two-step instruction
        cycle(1'b0, 4'd1);
        cycle(1'b0, 4'd2);
        cycle(1'b1, 4'd3);
        cycle(1'b0, 4'd4);
        cycle(1'b0, 4'd4);

        // random opcodes with occasional reset
        for (int k = 0; k < 3000; k++) begin
            cycle(($urandom % 50) == 0, 4'($urandom % 16));
        end
        @(negedge clk);
        compare();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule